// File: doc/BRIEF.md
# Handshaked GCD Engine with Full Scan

This block takes two unsigned words, one after the other, from a parallel input and returns their greatest common divisor on a parallel output. It works by repeated subtraction: on each clock the smaller operand is taken away from the larger one. When the two operands are equal, that value is the result.

The unit asks for each word with `req`. A word placed on `data_in` while `req` is high is captured on the next rising edge. An internal phase bit records whether the first or the second word of a pair is due. When the loop ends, `ready` pulses for one cycle while `data_out` carries the result. The unit then asks for the next pair on its own.

Every state flip-flop also belongs to one scan chain. While `scan_shift` is high, each bit loads its neighbour on every edge instead of its functional value, so any state can be shifted in or out. One edge with `scan_shift` low captures the functional next state, and that response can then be shifted out.

Top module: `gcd_scan_unit`

## Requirements
- R1: While `reset` is high at a rising edge, the state is set to: both operands 0, phase 0, `req` 1, `ready` 0. After that edge `data_out` reads 0 and `scan_out` reads 0.
- R2: In a cycle where `req` is high and the phase is 0, the next edge stores `data_in` as the first operand, which `data_out` then shows. It also sets the phase to 1, and `req` stays high for the second word.
- R3: In a cycle where `req` is high and the phase is 1, the next edge stores `data_in` as the second operand and clears both `req` and the phase.
- R4: When `ready` is high, `data_out` equals the greatest common divisor of the two words of the pair (both nonzero).
- R5: Let k be the number of subtractions that Euclid's method needs for the pair. `ready` first goes high in the cycle that begins k+1 edges after the edge that captured the second word.
- R6: `ready` is high for exactly one cycle. In the cycle after it, `req` is high and the phase is 0.
- R7: While `scan_shift` is high, each edge moves the chain by one place from `scan_in` toward `scan_out`. `scan_out` always shows the last chain bit, so a bit that enters at `scan_in` appears on `scan_out` after the chain length (2·width+3) of edges.
- R8: The chain bits, counted from the `scan_in` end, are: first operand bits 0..W-1 (LSB first), second operand bits W..2W-1, phase at 2W, `req` at 2W+1, `ready` at 2W+2. State loaded this way drives the outputs and the functional operation directly.
- R9: `scan_shift` overrides the functional update. While it is high, `data_in` and the handshake have no effect on the stored state.
- R10: One edge with `scan_shift` low, taken from any scanned-in state, stores the functional next state. Shifting the chain out afterwards returns that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| reset | input | 1 | Synchronous, active-high reset |
| data_in | input | WORD_W | Operand word, captured on the edge after `req` |
| req | output | 1 | High while the unit wants a word on `data_in` |
| ready | output | 1 | One-cycle pulse, result valid on `data_out` |
| data_out | output | WORD_W | First-operand register; holds the result when `ready` is high |
| scan_in | input | 1 | Serial input to the head of the scan chain |
| scan_shift | input | 1 | High: shift the chain; low: normal operation |
| scan_out | output | 1 | Tail of the scan chain (the `ready` flag) |

## Verification
Each word is due one edge after `req` is seen high. The first operand appears on `data_out` one edge later, and `req` falls one edge after the second word is taken. The result is due exactly k+1 edges after the second capture, where the bench counts k by running the subtraction loop itself. The bench therefore counts edges from the capture until `ready` appears and compares that count, and also checks that `ready` is low again one edge later. Scan checks drive and read at falling edges and count shifts exactly: a single marker bit must arrive at `scan_out` on shift N and not on shift N-1, and a scanned state must show the capture result after one functional edge.

// File: rtl/gcd_scan_pkg.sv
package gcd_scan_pkg;

    typedef enum logic [2:0] {
        OP_LOAD_FIRST,
        OP_LOAD_SECOND,
        OP_RESTART,
        OP_SUB_FIRST,
        OP_SUB_SECOND,
        OP_DONE
    } gcd_op_e;

    // Control flags; packed order puts phase at the lowest bit so the
    // chain reads phase, ask, done toward the scan output.
    typedef struct packed {
        logic done;
        logic ask;
        logic phase;
    } ctl_flags_t;

    localparam int FLAG_W = $bits(ctl_flags_t);

    function automatic int chain_len(input int word_w);
        return 2 * word_w + FLAG_W;
    endfunction

    function automatic ctl_flags_t flags_after_reset();
        ctl_flags_t f;
        f.done  = 1'b0;
        f.ask   = 1'b1;
        f.phase = 1'b0;
        return f;
    endfunction

endpackage

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
    import gcd_scan_pkg::*;
(
    input  ctl_flags_t flags_q,
    input  logic       first_gt,
    input  logic       second_gt,
    output gcd_op_e    op,
    output ctl_flags_t flags_d
);

    always_comb begin
        flags_d = '0;
        if (flags_q.ask) begin
            if (!flags_q.phase) begin
                op            = OP_LOAD_FIRST;
                flags_d.ask   = 1'b1;
                flags_d.phase = 1'b1;
            end else begin
                op            = OP_LOAD_SECOND;
            end
        end else if (flags_q.done) begin
            op          = OP_RESTART;
            flags_d.ask = 1'b1;
        end else if (first_gt) begin
            op = OP_SUB_FIRST;
        end else if (second_gt) begin
            op = OP_SUB_SECOND;
        end else begin
            op           = OP_DONE;
            flags_d.done = 1'b1;
        end
    end

endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath
    import gcd_scan_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  gcd_op_e           op,
    input  logic [WORD_W-1:0] word_in,
    input  logic [WORD_W-1:0] first_q,
    input  logic [WORD_W-1:0] second_q,
    output logic [WORD_W-1:0] first_d,
    output logic [WORD_W-1:0] second_d,
    output logic              first_gt,
    output logic              second_gt
);

    assign first_gt  = first_q > second_q;
    assign second_gt = second_q > first_q;

    always_comb begin
        first_d  = first_q;
        second_d = second_q;
        case (op)
            OP_LOAD_FIRST:  first_d  = word_in;
            OP_LOAD_SECOND: second_d = word_in;
            OP_SUB_FIRST:   first_d  = first_q - second_q;
            OP_SUB_SECOND:  second_d = second_q - first_q;
            default: begin
                first_d  = first_q;
                second_d = second_q;
            end
        endcase
    end

endmodule

// File: rtl/gcd_scan_reg.sv
module gcd_scan_reg #(
    parameter int CHAIN_N = 19
) (
    input  logic               clk,
    input  logic               reset,
    input  logic               shift_en,
    input  logic               scan_in,
    input  logic [CHAIN_N-1:0] func_d,
    input  logic [CHAIN_N-1:0] reset_val,
    output logic [CHAIN_N-1:0] q,
    output logic               scan_out
);

    logic [CHAIN_N-1:0] shift_src;
    logic [CHAIN_N-1:0] next_q;

    for (genvar i = 0; i < CHAIN_N; i++) begin : g_bit
        if (i == 0) begin : g_head
            assign shift_src[i] = scan_in;
        end else begin : g_link
            assign shift_src[i] = q[i-1];
        end
        assign next_q[i] = shift_en ? shift_src[i] : func_d[i];
    end

    always_ff @(posedge clk) begin
        if (reset) begin
            q <= reset_val;
        end else begin
            q <= next_q;
        end
    end

    assign scan_out = q[CHAIN_N-1];

    AST_SHIFT_HEAD: assert property (@(posedge clk) disable iff (reset)
        shift_en |=> q[0] == $past(scan_in)) else $error("scan head");  // R7

    AST_SHIFT_ADVANCE: assert property (@(posedge clk) disable iff (reset)
        shift_en |=> q[CHAIN_N-1:1] == $past(q[CHAIN_N-2:0])) else $error("scan advance");  // R9

endmodule

// File: rtl/gcd_scan_unit.sv
module gcd_scan_unit
    import gcd_scan_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              reset,
    input  logic [WORD_W-1:0] data_in,
    output logic              req,
    output logic              ready,
    output logic [WORD_W-1:0] data_out,
    input  logic              scan_in,
    input  logic              scan_shift,
    output logic              scan_out
);

    localparam int CHAIN_N = chain_len(WORD_W);
    localparam int OPS_W   = 2 * WORD_W;

    logic [CHAIN_N-1:0] state_q;
    logic [CHAIN_N-1:0] state_d;
    logic [CHAIN_N-1:0] state_rst;

    logic [WORD_W-1:0] first_q, second_q, first_d, second_d;
    ctl_flags_t        flags_q, flags_d;
    gcd_op_e           op;
    logic              first_gt, second_gt;

    assign first_q  = state_q[WORD_W-1:0];
    assign second_q = state_q[OPS_W-1:WORD_W];
    assign flags_q  = ctl_flags_t'(state_q[CHAIN_N-1:OPS_W]);

    assign state_d   = {flags_d, second_d, first_d};
    assign state_rst = {flags_after_reset(), {OPS_W{1'b0}}};

    gcd_ctrl u_ctrl (
        .flags_q   (flags_q),
        .first_gt  (first_gt),
        .second_gt (second_gt),
        .op        (op),
        .flags_d   (flags_d)
    );

    gcd_datapath #(.WORD_W(WORD_W)) u_datapath (
        .op        (op),
        .word_in   (data_in),
        .first_q   (first_q),
        .second_q  (second_q),
        .first_d   (first_d),
        .second_d  (second_d),
        .first_gt  (first_gt),
        .second_gt (second_gt)
    );

    gcd_scan_reg #(.CHAIN_N(CHAIN_N)) u_state (
        .clk       (clk),
        .reset     (reset),
        .shift_en  (scan_shift),
        .scan_in   (scan_in),
        .func_d    (state_d),
        .reset_val (state_rst),
        .q         (state_q),
        .scan_out  (scan_out)
    );

    assign req      = flags_q.ask;
    assign ready    = flags_q.done;
    assign data_out = first_q;

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (reset)
        (ready && !scan_shift) |=> !ready) else $error("ready pulse");  // R6

    AST_REQ_AFTER_READY: assert property (@(posedge clk) disable iff (reset)
        (ready && !req && !scan_shift) |=> (req && !flags_q.phase)) else $error("restart");  // R6

    AST_RESULT_SETTLED: assert property (@(posedge clk) disable iff (reset)
        (ready && !$past(scan_shift)) |-> (first_q == second_q)) else $error("result");  // R4

    AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (reset)
        (req && !scan_shift) |=> (flags_q.phase != $past(flags_q.phase))) else $error("phase");  // R3

endmodule

// File: tb/gcd_scan_unit_bench.sv
module gcd_scan_unit_bench;

    localparam int W = 4;
    localparam int N = 2 * W + 3;

    logic         clk = 1'b0;
    logic         reset;
    logic [W-1:0] data_in;
    logic         req, ready, scan_in, scan_shift, scan_out;
    logic [W-1:0] data_out;

    always #10 clk = ~clk;

    gcd_scan_unit #(.WORD_W(W)) u_gcd_scan_unit (
        .clk        (clk),
        .reset      (reset),
        .data_in    (data_in),
        .req        (req),
        .ready      (ready),
        .data_out   (data_out),
        .scan_in    (scan_in),
        .scan_shift (scan_shift),
        .scan_out   (scan_out)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<%0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic model(input int x, input int y, output int g, output int k);
        int a = x;
        int b = y;
        k = 0;
        while (a != b) begin
            if (a > b) a = a - b;
            else       b = b - a;
            k++;
        end
        g = a;
    endtask

    task automatic run_pair(input int x, input int y);
        int g, k, c, guard;
        guard = 0;
        while (!req && guard < 100) begin
            step();
            guard++;
        end
        data_in = x[W-1:0];
        step();
        chk("R2 req held for second word", req, 1);
        chk("R2 first operand on data_out", data_out, x);
        data_in = y[W-1:0];
        step();
        chk("R3 req dropped after second word", req, 0);
        model(x, y, g, k);
        c = 0;
        while (!ready && c < 300) begin
            step();
            c++;
        end
        chk("R5 ready latency", c, k + 1);
        chk("R4 gcd result", data_out, g);
        step();
        chk("R6 ready single cycle", ready, 0);
        chk("R6 req after ready", req, 1);
    endtask

    task automatic shift_bits(input logic [N-1:0] pat);
        scan_shift = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            scan_in = pat[i];
            step();
        end
        scan_shift = 1'b0;
        scan_in    = 1'b0;
    endtask

    task automatic read_chain(output logic [N-1:0] got);
        scan_shift = 1'b1;
        scan_in    = 1'b0;
        for (int i = 0; i < N; i++) begin
            got[N-1-i] = scan_out;
            step();
        end
        scan_shift = 1'b0;
    endtask

    initial begin
        logic [N-1:0] got;
        int guard;
        reset      = 1'b1;
        data_in    = '0;
        scan_in    = 1'b0;
        scan_shift = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        reset = 1'b0;

        chk("R1 reset req", req, 1);
        chk("R1 reset ready", ready, 0);
        chk("R1 reset data_out", data_out, 0);
        chk("R1 reset scan_out", scan_out, 0);

        for (int x = 1; x < (1 << W); x++) begin
            for (int y = 1; y < (1 << W); y++) begin
                run_pair(x, y);
            end
        end

        // R9: shifting zeros while req is high and data_in is nonzero
        data_in = 4'd7;
        shift_bits('0);
        chk("R9 data_in ignored during shift", data_out, 0);
        chk("R9 req from chain", req, 0);
        chk("R9 ready from chain", ready, 0);

        // R7: a single marker bit travels the chain length
        scan_shift = 1'b1;
        scan_in    = 1'b1;
        step();
        scan_in = 1'b0;
        repeat (N - 2) step();
        chk("R7 marker not yet at tail", scan_out, 0);
        step();
        chk("R7 marker at tail after N shifts", scan_out, 1);
        scan_shift = 1'b0;

        // R8: field positions, then functional continuation
        shift_bits({1'b0, 1'b1, 1'b1, 4'd9, 4'd5});
        chk("R8 first operand field", data_out, 5);
        chk("R8 req field", req, 1);
        chk("R8 ready field", ready, 0);
        chk("R8 tail is ready bit", scan_out, 0);
        data_in = 4'd3;
        step();
        chk("R8 scanned phase selects second word", req, 0);
        guard = 0;
        while (!ready && guard < 100) begin
            step();
            guard++;
        end
        chk("R8 gcd from scanned first operand", data_out, 1);

        shift_bits({1'b1, 1'b0, 1'b0, 4'd3, 4'd3});
        chk("R8 ready field set", ready, 1);
        chk("R8 tail shows ready", scan_out, 1);
        chk("R8 data_out field", data_out, 3);

        // R10: capture one functional step, then shift it out
        shift_bits({1'b0, 1'b0, 1'b0, 4'd4, 4'd6});
        step();
        read_chain(got);
        chk("R10 captured state", got, {1'b0, 1'b0, 1'b0, 4'd4, 4'd2});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule